// File: doc/BRIEF.md
# Watchdog and Interval Timer

This block holds one 8-bit up-counter that advances on ticks of a power-of-two prescaler running from the system clock. The same counter serves two roles, selected by a control bit. In interval mode each wrap from 0xFF to 0x00 sets an interval-overflow flag. In watchdog mode a wrap sets a watchdog-overflow flag and, when the reset-enable bit is set, emits a single-cycle reset request. The request goes to either the power-on-style output or the manual-style output, as a control bit selects. The interrupt output is a level. It is high while either flag is set and the interrupt-enable bit is 1.

Software reaches three registers through a single-cycle read and write port. Address 0 is the counter. Software may read it, write it, or rewrite it periodically to keep the watchdog from expiring. Address 1 is the control register. Address 2 is the status register, which is read-only and is cleared by reading it. `rdata` is a combinational view of the register selected by `addr`, whether or not `rd_en` is asserted. Distributing the reset through the system is outside this block.

A sequencer has five states. ST_OFF applies while the run bit is 0. ST_INTERVAL and ST_WATCH track the selected mode while the timer runs. ST_FIRE_POR and ST_FIRE_MAN each last one cycle and drive the matching reset request. The transitions are as follows. A watchdog wrap with reset enabled moves from any state to ST_FIRE_POR or ST_FIRE_MAN, according to the reset-kind bit. Otherwise the next state follows the control register: ST_OFF if the run bit is 0, ST_WATCH if the mode bit is 1, and ST_INTERVAL otherwise. The fire states leave by the same rule after one cycle.

Top module: `wdt_timer`

## Requirements
- R1: After reset the counter, control and status registers read 0, and `irq`, `por_req` and `man_req` are low.
- R2: Address 0 is the counter (read/write) and address 1 is the control register (read/write). Address 2 is the status register: bit 0 is interval overflow, bit 1 is watchdog overflow, and writes to it are ignored. Control bits: 7 run, 6 watchdog mode, 5 interrupt enable, 4 reset enable, 3 reset kind (0 power-on, 1 manual), 2:0 clock select.
- R3: While running, the counter advances once every 2^k clocks. Codes 000 to 111 give 2^k = 2, 8, 32, 64, 128, 512, 2048 and 8192. The first advance comes 2^k clocks after the clock edge that sets the run bit.
- R4: While the run bit is 0 the counter holds its value and the prescaler restarts from zero.
- R5: In interval mode a wrap from 0xFF to 0x00 sets status bit 0. Counting continues, and no reset request is made.
- R6: In watchdog mode a wrap sets status bit 1. With reset enable at 0, no reset request is made.
- R7: In watchdog mode with reset enable at 1, a wrap gives a pulse exactly one cycle long, in the cycle after the wrap edge. The pulse is on `por_req` if the reset kind is 0 and on `man_req` if it is 1.
- R8: `irq` is high while a status flag is set and interrupt enable is 1. It stays low whenever interrupt enable is 0.
- R9: A read of address 2 clears both flags. A wrap at the same edge sets its flag anyway.
- R10: A counter write at the same edge as a prescaler tick takes precedence, and no wrap is recorded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe; a read of the status register clears it |
| addr | input | 2 | Register select |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the register selected by `addr` |
| irq | output | 1 | Level interrupt |
| por_req | output | 1 | One-cycle power-on-style reset request |
| man_req | output | 1 | One-cycle manual-style reset request |

## Verification
The assertions check, on every cycle, the rules that need only local state:
- the prescaler never ticks on two edges in a row;
- a stopped counter with no write holds its value;
- a wrap always lands on zero and sets the right flag;
- reset requests last a single cycle and follow a qualified watchdog wrap;
- a status read clears the flags.

Only the bench's scenarios can show the exact tick period of each clock-select code and the cycle in which pulses and flags appear. The same holds for the precedence of a counter write over a tick, and for the fact that status writes have no effect. The bench shows these by comparing against a behavioural model.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    typedef enum logic [2:0] {
        ST_OFF      = 3'd0,
        ST_INTERVAL = 3'd1,
        ST_WATCH    = 3'd2,
        ST_FIRE_POR = 3'd3,
        ST_FIRE_MAN = 3'd4
    } wdt_state_e;

    localparam logic [1:0] ADDR_COUNT = 2'd0;
    localparam logic [1:0] ADDR_CTRL  = 2'd1;
    localparam logic [1:0] ADDR_STAT  = 2'd2;

    localparam int CB_RUN    = 7;
    localparam int CB_WDOG   = 6;
    localparam int CB_IEN    = 5;
    localparam int CB_RSTEN  = 4;
    localparam int CB_RSTSEL = 3;

    // log2 of the prescale ratio for each clock-select code
    function automatic int unsigned div_shift(input logic [2:0] code);
        case (code)
            3'd0:    return 1;
            3'd1:    return 3;
            3'd2:    return 5;
            3'd3:    return 6;
            3'd4:    return 7;
            3'd5:    return 9;
            3'd6:    return 11;
            default: return 13;
        endcase
    endfunction

endpackage

// File: rtl/wdt_prescale.sv
module wdt_prescale #(
    parameter int PRE_W = 13,
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);
    import wdt_pkg::*;

    logic [PRE_W-1:0] pre_q;
    logic [PRE_W-1:0] mask;

    always_comb begin
        mask = (PRE_W'(1) << div_shift(3'(sel))) - PRE_W'(1);
        tick = run && ((pre_q & mask) == mask);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    pre_q <= '0;
        else if (!run) pre_q <= '0;
        else           pre_q <= pre_q + PRE_W'(1);
    end

    // R3: the smallest ratio is 2, so ticks never fall on adjacent edges
    tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);

endmodule

// File: rtl/wdt_count.sv
module wdt_count #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic [W-1:0] value,
    output logic         wrap
);
    // a tick wraps the counter only if no write claims the same edge
    assign wrap = tick && !load && (value == {W{1'b1}});

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    value <= '0;
        else if (load) value <= load_val;
        else if (tick) value <= value + W'(1);
    end

    // R4
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !load) |=> $stable(value));

    // R5
    wrap_to_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> (value == '0));

endmodule

// File: rtl/wdt_seq.sv
module wdt_seq (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic wdog,
    input  logic rst_en,
    input  logic rst_sel,
    input  logic wrap,
    output logic por_req,
    output logic man_req
);
    import wdt_pkg::*;

    wdt_state_e state_q, state_d;

    always_comb begin
        if (wrap && wdog && rst_en)
            state_d = rst_sel ? ST_FIRE_MAN : ST_FIRE_POR;
        else if (!run)
            state_d = ST_OFF;
        else if (wdog)
            state_d = ST_WATCH;
        else
            state_d = ST_INTERVAL;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    always_comb begin
        por_req = 1'b0;
        man_req = 1'b0;
        unique case (state_q)
            ST_FIRE_POR: por_req = 1'b1;
            ST_FIRE_MAN: man_req = 1'b1;
            ST_OFF, ST_INTERVAL, ST_WATCH: ;
            default: ;
        endcase
    end

    // R7
    por_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        por_req |=> !por_req);

    // R7
    man_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        man_req |=> !man_req);

    // R7
    por_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        por_req |-> $past(wrap && wdog && rst_en && !rst_sel));

    // R6
    no_req_without_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap && !(wdog && rst_en)) |=> !(por_req || man_req));

endmodule

// File: rtl/wdt_timer.sv
module wdt_timer #(
    parameter int CNT_W = 8,
    parameter int PRE_W = 13,
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             rd_en,
    input  logic [1:0]       addr,
    input  logic [CNT_W-1:0] wdata,
    output logic [CNT_W-1:0] rdata,
    output logic             irq,
    output logic             por_req,
    output logic             man_req
);
    import wdt_pkg::*;

    localparam int STAT_BITS = 2;

    logic [CNT_W-1:0] ctrl_q;
    logic [CNT_W-1:0] count;
    logic             itv_flag, wdg_flag;
    logic             tick, wrap, cnt_load, stat_rd;

    assign cnt_load = wr_en && (addr == ADDR_COUNT);
    assign stat_rd  = rd_en && (addr == ADDR_STAT);

    wdt_prescale #(.PRE_W(PRE_W), .SEL_W(SEL_W)) u_pre (
        .clk (clk),
        .rst_n (rst_n),
        .run (ctrl_q[CB_RUN]),
        .sel (ctrl_q[SEL_W-1:0]),
        .tick (tick)
    );

    wdt_count #(.W(CNT_W)) u_cnt (
        .clk (clk),
        .rst_n (rst_n),
        .tick (tick),
        .load (cnt_load),
        .load_val (wdata),
        .value (count),
        .wrap (wrap)
    );

    wdt_seq u_seq (
        .clk (clk),
        .rst_n (rst_n),
        .run (ctrl_q[CB_RUN]),
        .wdog (ctrl_q[CB_WDOG]),
        .rst_en (ctrl_q[CB_RSTEN]),
        .rst_sel (ctrl_q[CB_RSTSEL]),
        .wrap (wrap),
        .por_req (por_req),
        .man_req (man_req)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                            ctrl_q <= '0;
        else if (wr_en && addr == ADDR_CTRL)   ctrl_q <= wdata;
    end

    // a wrap at the same edge as a status read wins
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            itv_flag <= 1'b0;
            wdg_flag <= 1'b0;
        end else begin
            itv_flag <= (itv_flag && !stat_rd) || (wrap && !ctrl_q[CB_WDOG]);
            wdg_flag <= (wdg_flag && !stat_rd) || (wrap &&  ctrl_q[CB_WDOG]);
        end
    end

    always_comb begin
        case (addr)
            ADDR_COUNT: rdata = count;
            ADDR_CTRL:  rdata = ctrl_q;
            ADDR_STAT:  rdata = {{(CNT_W-STAT_BITS){1'b0}}, wdg_flag, itv_flag};
            default:    rdata = '0;
        endcase
    end

    assign irq = ctrl_q[CB_IEN] && (itv_flag || wdg_flag);

    // R9
    stat_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && !wrap) |=> (!itv_flag && !wdg_flag));

    // R5
    itv_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap && !ctrl_q[CB_WDOG]) |=> itv_flag);

    // R6
    wdg_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap && ctrl_q[CB_WDOG]) |=> wdg_flag);

endmodule

// File: tb/wdt_timer_test.sv
`timescale 1ns/1ps
module wdt_timer_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [1:0] addr = 2'd0;
    logic [7:0] wdata = 8'd0;
    logic [7:0] rdata;
    logic       irq, por_req, man_req;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    int por_seen = 0;
    int man_seen = 0;

    // reference model state
    int m_cnt = 0, m_ctrl = 0, m_itv = 0, m_wdg = 0, m_pre = 0, m_kick = 0;
    int t_mask, t_cnt, t_itv, t_wdg, t_kick;
    bit t_tick, t_wrap;

    wdt_timer uut (
        .clk (clk), .rst_n (rst_n), .wr_en (wr_en), .rd_en (rd_en),
        .addr (addr), .wdata (wdata), .rdata (rdata),
        .irq (irq), .por_req (por_req), .man_req (man_req)
    );

    always #2.5 clk = ~clk;

    function automatic int ratio(input int code);
        int r [8] = '{2, 8, 32, 64, 128, 512, 2048, 8192};
        return r[code & 7];
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // behavioural model, advanced on every rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0; m_ctrl = 0; m_itv = 0; m_wdg = 0; m_pre = 0; m_kick = 0;
        end else begin
            t_mask = ratio(m_ctrl) - 1;
            t_tick = m_ctrl[7] && ((m_pre & t_mask) == t_mask);
            t_wrap = t_tick && (m_cnt == 255) && !(wr_en && addr == 2'd0);
            t_cnt = m_cnt;
            if (wr_en && addr == 2'd0) t_cnt = wdata;
            else if (t_tick)            t_cnt = (m_cnt + 1) % 256;
            t_itv = m_itv; t_wdg = m_wdg;
            if (rd_en && addr == 2'd2) begin t_itv = 0; t_wdg = 0; end
            if (t_wrap && !m_ctrl[6]) t_itv = 1;
            if (t_wrap &&  m_ctrl[6]) t_wdg = 1;
            t_kick = 0;
            if (t_wrap && m_ctrl[6] && m_ctrl[4]) t_kick = m_ctrl[3] ? 2 : 1;
            m_pre = m_ctrl[7] ? (m_pre + 1) % 8192 : 0;
            if (wr_en && addr == 2'd1) m_ctrl = wdata;
            m_cnt = t_cnt; m_itv = t_itv; m_wdg = t_wdg; m_kick = t_kick;
        end
    end

    // per-cycle comparison away from the rising edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            automatic int exp_rd = (addr == 2'd0) ? m_cnt :
                                   (addr == 2'd1) ? m_ctrl :
                                   (addr == 2'd2) ? (m_wdg * 2 + m_itv) : 0;
            chk(irq == (m_ctrl[5] && (m_itv || m_wdg)), "R8 irq", irq, m_ctrl[5] && (m_itv || m_wdg));
            chk(por_req == (m_kick == 1), "R7 por_req", por_req, m_kick == 1);
            chk(man_req == (m_kick == 2), "R7 man_req", man_req, m_kick == 2);
            chk(rdata == exp_rd[7:0], "R2 rdata", rdata, exp_rd);
            if (por_req) por_seen++;
            if (man_req) man_seen++;
        end
    end

    task automatic reg_write(input logic [1:0] a, input logic [7:0] d);
        @(posedge clk); #1;
        wr_en = 1'b1; addr = a; wdata = d;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic reg_read(input logic [1:0] a, output int v);
        @(posedge clk); #1;
        rd_en = 1'b1; addr = a;
        #3 v = rdata;
        @(posedge clk); #1;
        rd_en = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
    endtask

    // stop, preload the counter, then start with the given control value
    task automatic arm(input logic [7:0] cnt, input logic [7:0] ctl);
        int junk;
        reg_write(2'd1, 8'h00);
        reg_write(2'd0, cnt);
        reg_read(2'd2, junk);
        reg_write(2'd1, ctl);
    endtask

    initial begin
        #(5.0 * 150000);
        checks++; errors++;
        $display("FAIL watchdog expired at %0t", $time);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int v, p0, m0;
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        reg_read(2'd0, v); chk(v == 0, "R1 counter", v, 0);
        reg_read(2'd1, v); chk(v == 0, "R1 control", v, 0);
        reg_read(2'd2, v); chk(v == 0, "R1 status", v, 0);
        chk(!irq && !por_req && !man_req, "R1 outputs", {irq, por_req, man_req}, 0);

        // R4 stopped counter holds
        reg_write(2'd0, 8'h55);
        idle(20);
        reg_read(2'd0, v); chk(v == 8'h55, "R4 hold", v, 8'h55);

        // R2 status write on clear flags has no effect
        reg_write(2'd2, 8'hFF);
        reg_read(2'd2, v); chk(v == 0, "R2 status write", v, 0);

        // R5 interval wrap, R8 irq
        arm(8'hFC, 8'hA0);
        idle(12);
        chk(irq == 1'b1, "R8 irq high", irq, 1);
        reg_write(2'd2, 8'h00);
        reg_read(2'd2, v); chk(v == 1, "R5 itv flag", v, 1);
        reg_read(2'd2, v); chk(v == 0, "R9 cleared", v, 0);
        reg_read(2'd0, v); chk(v > 0 && v < 8'h20, "R5 counting on", v, 8);

        // R8 interrupt disabled
        arm(8'hFC, 8'h80);
        idle(12);
        chk(irq == 1'b0, "R8 irq masked", irq, 0);
        reg_read(2'd2, v); chk(v == 1, "R8 flag kept", v, 1);

        // R6 watchdog without reset
        p0 = por_seen; m0 = man_seen;
        arm(8'hFC, 8'hE0);
        idle(12);
        reg_read(2'd2, v); chk(v == 2, "R6 wdg flag", v, 2);
        chk(por_seen == p0 && man_seen == m0, "R6 no request", por_seen + man_seen - p0 - m0, 0);

        // R7 power-on style request
        p0 = por_seen; m0 = man_seen;
        arm(8'hFC, 8'hF0);
        idle(12);
        chk(por_seen - p0 == 1, "R7 por pulse", por_seen - p0, 1);
        chk(man_seen == m0, "R7 no man", man_seen - m0, 0);

        // R7 manual style request
        p0 = por_seen; m0 = man_seen;
        arm(8'hFC, 8'hF8);
        idle(12);
        chk(man_seen - m0 == 1, "R7 man pulse", man_seen - m0, 1);
        chk(por_seen == p0, "R7 no por", por_seen - p0, 0);
        reg_read(2'd2, v); chk(v == 2, "R7 wdg flag", v, 2);

        // R10 constant rewrite of 0xFF keeps the counter from wrapping
        arm(8'hFF, 8'h80);
        @(posedge clk); #1;
        wr_en = 1'b1; addr = 2'd0; wdata = 8'hFF;
        repeat (20) @(posedge clk);
        #1 wdata = 8'h10;
        @(posedge clk); #1 wr_en = 1'b0;
        reg_read(2'd2, v); chk(v == 0, "R10 no wrap", v, 0);

        // R3 prescale ratio for every code
        for (int c = 0; c < 8; c++) begin
            reg_write(2'd1, 8'h00);
            reg_write(2'd0, 8'h00);
            reg_write(2'd1, 8'h80 | c[7:0]);
            idle(3 * ratio(c) - 1);
            reg_read(2'd0, v); chk(v == 3, $sformatf("R3 code %0d", c), v, 3);
        end

        reg_write(2'd1, 8'h00);
        idle(2);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule